// File: doc/BRIEF.md
# Dual-Source Prioritised Interrupt Responder

This block combines two internal interrupt sources into a single processor interrupt. One source is a parity-fault request and the other is an Ethernet-controller request. Each request is held in its own pending flag. While either flag is set, the block raises one interrupt. The interrupt's priority level is chosen by a configuration bit, and a second bit chooses how that level appears on the three active-low interrupt pins: as one asserted line per level, or as a binary-encoded level.

When the processor runs an acknowledge cycle for the level this block currently uses, the block places an 8-bit vector on its response port and pulses a valid strobe for one clock. The parity fault always wins. The Ethernet vector is returned only once no parity fault is pending. Both vectors sit in small registers that can be rewritten through a write port, so the interrupt handler addresses can be relocated.

Top module: `dual_irq_responder`

## Requirements
- R1: After reset, `irq_n_o` is 3'b111, `vec_vld_o` is 0, neither request is pending, the parity vector holds 8'h40 and the Ethernet vector holds 8'h41.
- R2: A request pulse sets its pending flag, and the flag stays set until its clear input is pulsed. When request and clear of the same source fall in the same cycle, the flag ends up set.
- R3: The active level is 5 when `lvl_sel_i` is 0 and 3 when it is 1.
- R4: With `ipl_mode_i`=1 and something pending, `irq_n_o` carries the bitwise inverse of the active level: 3'b010 for level 5 and 3'b100 for level 3.
- R5: With `ipl_mode_i`=0 and something pending, exactly one pin is driven low: bit 1 for level 5 (3'b101) and bit 0 for level 3 (3'b110).
- R6: `irq_n_o` returns to 3'b111 two clock edges after the last pending flag is cleared.
- R7: An acknowledge starts on the rising edge of `ack_vld_i`. A matching acknowledge produces `vec_vld_o`=1 for exactly one cycle, one edge later, together with the vector on `vec_o`.
- R8: When both flags are pending, the parity vector is returned. The Ethernet vector is returned only when the parity flag is clear.
- R9: An acknowledge whose `ack_lvl_i` differs from the active level, or that arrives with nothing pending, leaves `vec_vld_o` at 0.
- R10: A write with `vec_wr_i`=1 loads `vec_wdata_i` into the parity vector when `vec_sel_i`=0 and into the Ethernet vector when `vec_sel_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_req_i | input | 1 | Parity-fault request (sets pending) |
| par_clr_i | input | 1 | Parity-fault clear strobe |
| eth_req_i | input | 1 | Ethernet request (sets pending) |
| eth_clr_i | input | 1 | Ethernet clear strobe |
| lvl_sel_i | input | 1 | 0: level 5, 1: level 3 |
| ipl_mode_i | input | 1 | 0: one line per level, 1: encoded level |
| ack_vld_i | input | 1 | Acknowledge cycle active |
| ack_lvl_i | input | 3 | Level being acknowledged |
| vec_wr_i | input | 1 | Vector register write strobe |
| vec_sel_i | input | 1 | Vector register select (0 parity, 1 Ethernet) |
| vec_wdata_i | input | 8 | Vector write data |
| irq_n_o | output | 3 | Active-low interrupt pins |
| vec_o | output | 8 | Response vector |
| vec_vld_o | output | 1 | Response strobe, one cycle |

## Verification
A request or clear changes its pending flag at the next edge. The interrupt pins follow one edge after that, so they are due two edges after the stimulus. An acknowledge answer, and a silent non-answer, is due one edge after the rising edge of `ack_vld_i`, and the strobe must be low again one edge after that. Each expected item in the scoreboard carries the cycle number at which it is due. The monitor compares items only in that cycle, sampling on the falling clock edge, so every result is judged at the exact latency and not merely at some later point.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  // Number of merged sources; index 0 carries the highest priority.
  localparam int unsigned SRC_CNT = 2;
  localparam int unsigned SRC_PAR = 0;
  localparam int unsigned SRC_ETH = 1;

  typedef enum logic {
    PIN_LINES = 1'b0,
    PIN_CODED = 1'b1
  } pin_mode_e;

  // Active level picked by the level-select bit.
  function automatic logic [2:0] active_level(input logic lo_sel,
                                              input logic [2:0] hi_lvl,
                                              input logic [2:0] lo_lvl);
    return lo_sel ? lo_lvl : hi_lvl;
  endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  // A new event takes precedence over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  // R2: a request leaves the flag set
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
    set_i |=> pend_o);

  // R2: the flag holds until cleared
  a_r2_hold_until_clear: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !clr_i) |=> pend_o);

  // R2: a lone clear drops the flag
  a_r2_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !pend_o);

endmodule

// File: rtl/irq_vec_store.sv
module irq_vec_store #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned SEL_W   = 1,
  parameter logic [NUM_SRC*VEC_W-1:0] RST_VALS = '0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [VEC_W-1:0]                wdata_i,
  output logic [NUM_SRC-1:0][VEC_W-1:0]   vec_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (sel_i == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst)      vec_o[g] <= RST_VALS[g*VEC_W +: VEC_W];
      else if (hit) vec_o[g] <= wdata_i;
    end

    // R10: a selected write lands in this slot
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_i && sel_i == SEL_W'(g)) |=> (vec_o[g] == $past(wdata_i)));

    // R10: an unselected slot keeps its value
    a_r10_other_kept: assert property (@(posedge clk) disable iff (rst)
      !(wr_i && sel_i == SEL_W'(g)) |=> $stable(vec_o[g]));
  end

endmodule

// File: rtl/irq_out_encoder.sv
module irq_out_encoder
  import irq_merge_pkg::*;
#(
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned LVL_HI  = 5,
  parameter int unsigned LVL_LO  = 3,
  parameter int unsigned LINE_HI = 1,
  parameter int unsigned LINE_LO = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_pend_i,
  input  logic             lvl_sel_i,
  input  logic             mode_i,
  output logic [LVL_W-1:0] irq_n_o
);

  localparam logic [LVL_W-1:0] HI_CODE = LVL_W'(LVL_HI);
  localparam logic [LVL_W-1:0] LO_CODE = LVL_W'(LVL_LO);

  logic [LVL_W-1:0] lvl;
  logic [LVL_W-1:0] nxt;

  assign lvl = lvl_sel_i ? LO_CODE : HI_CODE;

  always_comb begin
    nxt = '1;
    if (any_pend_i) begin
      if (pin_mode_e'(mode_i) == PIN_CODED) begin
        nxt = ~lvl;
      end else if (lvl_sel_i) begin
        nxt[LINE_LO] = 1'b0;
      end else begin
        nxt[LINE_HI] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= '1;
    else     irq_n_o <= nxt;
  end

  // R6: no pending source means idle pins
  a_r6_idle_pins: assert property (@(posedge clk) disable iff (rst)
    !any_pend_i |=> (irq_n_o == '1));

  // R4 and R3: coded mode at the high level
  a_r4_coded_hi: assert property (@(posedge clk) disable iff (rst)
    (any_pend_i && mode_i && !lvl_sel_i) |=> (irq_n_o == ~HI_CODE));

  // R4 and R3: coded mode at the low level
  a_r4_coded_lo: assert property (@(posedge clk) disable iff (rst)
    (any_pend_i && mode_i && lvl_sel_i) |=> (irq_n_o == ~LO_CODE));

  // R5: line mode drives exactly one pin
  a_r5_single_line: assert property (@(posedge clk) disable iff (rst)
    (any_pend_i && !mode_i) |=> ($countones(~irq_n_o) == 1));

endmodule

// File: rtl/irq_ack_responder.sv
module irq_ack_responder
  import irq_merge_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned LVL_HI  = 5,
  parameter int unsigned LVL_LO  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0][VEC_W-1:0] vecs_i,
  input  logic                          lvl_sel_i,
  input  logic                          ack_vld_i,
  input  logic [LVL_W-1:0]              ack_lvl_i,
  output logic [VEC_W-1:0]              vec_o,
  output logic                          vld_o
);

  logic             ack_q;
  logic             ack_edge;
  logic             lvl_match;
  logic             any_pend;
  logic             answer;
  logic [VEC_W-1:0] pick;

  assign ack_edge  = ack_vld_i && !ack_q;
  assign lvl_match = (ack_lvl_i == active_level(lvl_sel_i, LVL_W'(LVL_HI), LVL_W'(LVL_LO)));
  assign any_pend  = |pend_i;
  assign answer    = ack_edge && lvl_match && any_pend;

  // Fixed priority: walk from the lowest source up so index 0 wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) pick = vecs_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      vld_o <= 1'b0;
      vec_o <= '0;
    end else begin
      ack_q <= ack_vld_i;
      vld_o <= answer;
      if (answer) vec_o <= pick;
    end
  end

  // R7: the strobe never lasts two cycles
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o);

  // R7: a valid answer is always preceded by a rising acknowledge
  a_r7_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(vld_o) |-> $past(ack_vld_i));

  // R8: the top source wins whenever it is pending
  a_r8_top_wins: assert property (@(posedge clk) disable iff (rst)
    (ack_edge && lvl_match && pend_i[0]) |=> (vld_o && vec_o == $past(vecs_i[0])));

  // R8: the second source is served only when the first is clear
  a_r8_second_only: assert property (@(posedge clk) disable iff (rst)
    (ack_edge && lvl_match && !pend_i[0] && pend_i[1]) |=> (vld_o && vec_o == $past(vecs_i[1])));

  // R9: level mismatch stays silent
  a_r9_wrong_level: assert property (@(posedge clk) disable iff (rst)
    (ack_edge && !lvl_match) |=> !vld_o);

  // R9: nothing pending stays silent
  a_r9_nothing_pending: assert property (@(posedge clk) disable iff (rst)
    !any_pend |=> !vld_o);

endmodule

// File: rtl/dual_irq_responder.sv
module dual_irq_responder
  import irq_merge_pkg::*;
#(
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned LVL_HI      = 5,
  parameter int unsigned LVL_LO      = 3,
  parameter int unsigned LINE_HI     = 1,
  parameter int unsigned LINE_LO     = 0,
  parameter logic [7:0]  PAR_VEC_RST = 8'h40,
  parameter logic [7:0]  ETH_VEC_RST = 8'h41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             par_req_i,
  input  logic             par_clr_i,
  input  logic             eth_req_i,
  input  logic             eth_clr_i,
  input  logic             lvl_sel_i,
  input  logic             ipl_mode_i,
  input  logic             ack_vld_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             vec_wr_i,
  input  logic             vec_sel_i,
  input  logic [VEC_W-1:0] vec_wdata_i,
  output logic [LVL_W-1:0] irq_n_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);

  localparam int unsigned NSRC  = SRC_CNT;
  localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [NSRC*VEC_W-1:0] RST_PACK =
    {VEC_W'(ETH_VEC_RST), VEC_W'(PAR_VEC_RST)};

  logic [NSRC-1:0]            set_v;
  logic [NSRC-1:0]            clr_v;
  logic [NSRC-1:0]            pend_v;
  logic [NSRC-1:0][VEC_W-1:0] vecs;

  assign set_v[SRC_PAR] = par_req_i;
  assign set_v[SRC_ETH] = eth_req_i;
  assign clr_v[SRC_PAR] = par_clr_i;
  assign clr_v[SRC_ETH] = eth_clr_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_pend_latch u_pend (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_v[s]),
      .clr_i  (clr_v[s]),
      .pend_o (pend_v[s])
    );
  end

  irq_vec_store #(
    .NUM_SRC  (NSRC),
    .VEC_W    (VEC_W),
    .SEL_W    (SEL_W),
    .RST_VALS (RST_PACK)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (vec_wr_i),
    .sel_i   (SEL_W'(vec_sel_i)),
    .wdata_i (vec_wdata_i),
    .vec_o   (vecs)
  );

  irq_out_encoder #(
    .LVL_W   (LVL_W),
    .LVL_HI  (LVL_HI),
    .LVL_LO  (LVL_LO),
    .LINE_HI (LINE_HI),
    .LINE_LO (LINE_LO)
  ) u_enc (
    .clk        (clk),
    .rst        (rst),
    .any_pend_i (|pend_v),
    .lvl_sel_i  (lvl_sel_i),
    .mode_i     (ipl_mode_i),
    .irq_n_o    (irq_n_o)
  );

  irq_ack_responder #(
    .NUM_SRC (NSRC),
    .VEC_W   (VEC_W),
    .LVL_W   (LVL_W),
    .LVL_HI  (LVL_HI),
    .LVL_LO  (LVL_LO)
  ) u_resp (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend_v),
    .vecs_i    (vecs),
    .lvl_sel_i (lvl_sel_i),
    .ack_vld_i (ack_vld_i),
    .ack_lvl_i (ack_lvl_i),
    .vec_o     (vec_o),
    .vld_o     (vec_vld_o)
  );

endmodule

// File: tb/dual_irq_responder_tb_top.sv
module dual_irq_responder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_req_i = 1'b0, par_clr_i = 1'b0;
  logic       eth_req_i = 1'b0, eth_clr_i = 1'b0;
  logic       lvl_sel_i = 1'b0, ipl_mode_i = 1'b0;
  logic       ack_vld_i = 1'b0;
  logic [2:0] ack_lvl_i = 3'd0;
  logic       vec_wr_i = 1'b0, vec_sel_i = 1'b0;
  logic [7:0] vec_wdata_i = 8'h00;
  logic [2:0] irq_n_o;
  logic [7:0] vec_o;
  logic       vec_vld_o;

  always #10 clk = ~clk;  // 50 MHz

  dual_irq_responder dut_i (
    .clk(clk), .rst(rst),
    .par_req_i(par_req_i), .par_clr_i(par_clr_i),
    .eth_req_i(eth_req_i), .eth_clr_i(eth_clr_i),
    .lvl_sel_i(lvl_sel_i), .ipl_mode_i(ipl_mode_i),
    .ack_vld_i(ack_vld_i), .ack_lvl_i(ack_lvl_i),
    .vec_wr_i(vec_wr_i), .vec_sel_i(vec_sel_i), .vec_wdata_i(vec_wdata_i),
    .irq_n_o(irq_n_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
  );

  typedef struct {
    int         due;
    bit         is_vec;
    bit         vld;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: queue an expectation, kept sorted by due cycle.
  task automatic expect_item(int off, bit is_vec, bit vld, logic [7:0] val, string tag);
    exp_t it;
    int   pos;
    it.due = cyc + off; it.is_vec = is_vec; it.vld = vld; it.val = val; it.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].due > it.due) begin pos = i; break; end
    end
    sb.insert(pos, it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Monitor: compare every item whose due cycle has come.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      n_chk++;
      if (it.is_vec) begin
        if (vec_vld_o !== it.vld || (it.vld && vec_o !== it.val)) begin
          n_bad++;
          $display("FAIL %s: actual vld=%0b vec=%02h expected vld=%0b vec=%02h",
                   it.tag, vec_vld_o, vec_o, it.vld, it.val);
        end
      end else if (irq_n_o !== it.val[2:0]) begin
        n_bad++;
        $display("FAIL %s: actual irq_n=%03b expected irq_n=%03b",
                 it.tag, irq_n_o, it.val[2:0]);
      end
    end
  end

  // Rising acknowledge, held two cycles to prove the strobe is single.
  task automatic do_ack(logic [2:0] lvl, bit exp_vld, logic [7:0] exp_vec, string tag);
    ack_lvl_i = lvl;
    ack_vld_i = 1'b1;
    expect_item(1, 1'b1, exp_vld, exp_vec, tag);
    tick();
    expect_item(1, 1'b1, 1'b0, 8'h00, {tag, " single strobe R7"});
    tick();
    ack_vld_i = 1'b0;
    tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    expect_item(1, 1'b0, 1'b0, 8'h07, "R1 reset pins");
    expect_item(1, 1'b1, 1'b0, 8'h00, "R1 reset strobe");
    tick(); tick();
    do_ack(3'd5, 1'b0, 8'h00, "R9 nothing pending after reset");

    // Coded mode, level 5, parity request
    ipl_mode_i = 1'b1; lvl_sel_i = 1'b0;
    par_req_i = 1'b1;
    expect_item(2, 1'b0, 1'b0, 8'h02, "R4 R3 coded level 5");
    tick(); par_req_i = 1'b0;
    tick(); tick(); tick();
    expect_item(1, 1'b0, 1'b0, 8'h02, "R2 pending held");
    tick();
    do_ack(3'd5, 1'b1, 8'h40, "R7 R1 parity reset vector");

    // Both pending
    eth_req_i = 1'b1; tick(); eth_req_i = 1'b0; tick();
    do_ack(3'd5, 1'b1, 8'h40, "R8 parity wins over ethernet");
    do_ack(3'd3, 1'b0, 8'h00, "R9 level mismatch");

    // Clear parity, ethernet served now
    par_clr_i = 1'b1; tick(); par_clr_i = 1'b0; tick();
    do_ack(3'd5, 1'b1, 8'h41, "R8 ethernet after parity cleared");
    expect_item(1, 1'b0, 1'b0, 8'h02, "R6 still raised with ethernet pending");
    tick();

    // Same-cycle set and clear keeps pending
    eth_req_i = 1'b1; eth_clr_i = 1'b1; tick();
    eth_req_i = 1'b0; eth_clr_i = 1'b0; tick();
    do_ack(3'd5, 1'b1, 8'h41, "R2 set wins over clear");

    // Final clear goes idle
    eth_clr_i = 1'b1;
    expect_item(2, 1'b0, 1'b0, 8'h07, "R6 idle after clear");
    tick(); eth_clr_i = 1'b0; tick(); tick();
    do_ack(3'd5, 1'b0, 8'h00, "R9 silent with nothing pending");

    // Rewrite both vectors
    vec_wr_i = 1'b1; vec_sel_i = 1'b0; vec_wdata_i = 8'hA5; tick();
    vec_sel_i = 1'b1; vec_wdata_i = 8'h3C; tick();
    vec_wr_i = 1'b0; tick();

    // Line mode, level 3, ethernet request
    ipl_mode_i = 1'b0; lvl_sel_i = 1'b1;
    eth_req_i = 1'b1;
    expect_item(2, 1'b0, 1'b0, 8'h06, "R5 R3 line level 3");
    tick(); eth_req_i = 1'b0; tick(); tick();
    do_ack(3'd5, 1'b0, 8'h00, "R9 level 5 ignored while at level 3");
    do_ack(3'd3, 1'b1, 8'h3C, "R10 ethernet vector rewritten");

    lvl_sel_i = 1'b0;
    expect_item(2, 1'b0, 1'b0, 8'h05, "R5 line level 5");
    tick(); tick(); tick();

    ipl_mode_i = 1'b1; lvl_sel_i = 1'b1;
    expect_item(2, 1'b0, 1'b0, 8'h04, "R4 coded level 3");
    tick(); tick(); tick();

    par_req_i = 1'b1; tick(); par_req_i = 1'b0; tick();
    do_ack(3'd3, 1'b1, 8'hA5, "R10 R8 parity vector rewritten");

    par_clr_i = 1'b1; eth_clr_i = 1'b1;
    expect_item(2, 1'b0, 1'b0, 8'h07, "R6 idle after both cleared");
    tick(); par_clr_i = 1'b0; eth_clr_i = 1'b0;
    repeat (5) tick();

    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R7 scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule